// File: doc/BRIEF.md
# Serial EEPROM Word Read Sequencer

This block fetches one word from a three-wire serial EEPROM. A host gives it a word address and a one-cycle start strobe. The block then drives the select, serial clock and serial data lines through a fixed sequence of pin states, which runs in this order:

- a dummy clock preamble;
- a start bit;
- the two-bit read command;
- the address;
- the sixteen returned data bits;
- a deselect tail.

It samples the EEPROM's data line while the sequence runs. At the end it presents the received word with its two bytes exchanged and pulses `done` for one cycle.

Every change of the pin state is followed by a settling time of `STEP_CYCLES` system clocks before the next change. The whole read therefore takes a fixed number of cycles. With the default widths the sequence has 63 steps, so a read lasts 63 × `STEP_CYCLES` cycles.

Top module: `eeprom_word_reader`

## Requirements
- R1: While reset is asserted, and after it is released, `busy`, `done`, `mem_cs`, `mem_sck`, `mem_mosi` and `rd_data` are all 0.
- R2: A `start` while idle latches `rd_addr`. `busy` is 1 from the next cycle, and the pin outputs show the first step (all low) in that cycle.
- R3: Every pin state is held for exactly `STEP_CYCLES` cycles before the next step's state is applied.
- R4: The preamble is made of four steps, written here as {cs,sck,mosi}: 000, 100, 110, 100.
- R5: The command comes next. With cs high, the bits 1, 1, 0 are sent (start bit, then read command 1,0), followed by the 8 address bits MSB first. Each bit is sent as two steps: first with sck=0, then with sck=1 and the same data. After the last address bit, one step of 100 follows.
- R6: Sixteen data bits are read MSB first. Each bit takes two steps: 110, then 100. `mem_miso` is sampled at the end of the 100 step.
- R7: The tail is made of four steps: 000, 100, 000, 010. After the read ends the pins stay at 010 until the next start.
- R8: The result on `rd_data` is the received word with its upper and lower byte exchanged. It appears together with a one-cycle `done` pulse, in the same cycle that `busy` falls, and it is held until the next read completes.
- R9: A `start` while `busy` is 1 is ignored. The address sent and the word returned are those of the read already in progress.
- R10: `done` rises exactly 63 × `STEP_CYCLES` cycles after the cycle in which `busy` first reads 1, counting that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to read a word |
| rd_addr | input | ADDR_W | Word address, sampled at an accepted start |
| busy | output | 1 | Read sequence in progress |
| done | output | 1 | One-cycle pulse when `rd_data` is updated |
| rd_data | output | DATA_W | Byte-swapped word from the last read |
| mem_cs | output | 1 | EEPROM chip select |
| mem_sck | output | 1 | EEPROM serial clock |
| mem_mosi | output | 1 | Serial data toward the EEPROM |
| mem_miso | input | 1 | Serial data from the EEPROM |

## Verification
The bench builds the block with the default 8-bit address and 16-bit word, and with `STEP_CYCLES` = 2. This keeps a read short enough for many random addresses to run. It still makes every step last more than one cycle, so a hold that is too short or too long by one cycle shows up in the per-cycle pin comparison. An EEPROM model answers only after it has seen a start bit, and it decodes the command and address from the clock edges. A wrong preamble, bit order or address therefore shows up as a wrong returned word or header.

// File: rtl/eerd_pkg.sv
package eerd_pkg;

  typedef struct packed {
    logic cs;
    logic sck;
    logic mosi;
  } ee_pins_t;

  localparam int PREAMBLE_STEPS = 4;
  localparam int CMD_STEPS      = 6;  // start bit and two command bits, two steps each
  localparam int GAP_STEPS      = 1;
  localparam int TAIL_STEPS     = 4;

  function automatic int total_steps(input int addr_w, input int data_w);
    return PREAMBLE_STEPS + CMD_STEPS + 2 * addr_w + GAP_STEPS + 2 * data_w + TAIL_STEPS;
  endfunction

endpackage

// File: rtl/eerd_step_timer.sv
module eerd_step_timer #(
  parameter int STEP_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic step_end
);
  localparam int CNT_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;

  assign step_end = run && (cnt_q == CNT_LAST);

  always_comb begin
    if (clear || !run || step_end) cnt_n = '0;
    else                           cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/eerd_step_decode.sv
module eerd_step_decode
  import eerd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int STEP_W = 6
) (
  input  logic [STEP_W-1:0] step,
  input  logic              addr_msb,
  output ee_pins_t          pins,
  output logic              shift_addr,
  output logic              sample_bit
);
  localparam int S_CMD  = PREAMBLE_STEPS;
  localparam int S_ADR  = S_CMD + CMD_STEPS;
  localparam int S_GAP  = S_ADR + 2 * ADDR_W;
  localparam int S_DAT  = S_GAP + GAP_STEPS;
  localparam int S_TAIL = S_DAT + 2 * DATA_W;

  localparam logic [STEP_W-1:0] L_CMD  = STEP_W'(S_CMD);
  localparam logic [STEP_W-1:0] L_ADR  = STEP_W'(S_ADR);
  localparam logic [STEP_W-1:0] L_GAP  = STEP_W'(S_GAP);
  localparam logic [STEP_W-1:0] L_DAT  = STEP_W'(S_DAT);
  localparam logic [STEP_W-1:0] L_TAIL = STEP_W'(S_TAIL);
  localparam logic [STEP_W-1:0] L_ONES = STEP_W'(4);  // steps carrying start bit and first command bit

  logic [STEP_W-1:0] rel;

  always_comb begin
    pins       = '0;
    shift_addr = 1'b0;
    sample_bit = 1'b0;
    rel        = '0;
    if (step < L_CMD) begin
      case (step[1:0])
        2'd1:    pins.cs = 1'b1;
        2'd2:    begin pins.cs = 1'b1; pins.sck = 1'b1; end
        2'd3:    pins.cs = 1'b1;
        default: pins = '0;
      endcase
    end else if (step < L_ADR) begin
      rel       = step - L_CMD;
      pins.cs   = 1'b1;
      pins.sck  = rel[0];
      pins.mosi = (rel < L_ONES);
    end else if (step < L_GAP) begin
      rel        = step - L_ADR;
      pins.cs    = 1'b1;
      pins.sck   = rel[0];
      pins.mosi  = addr_msb;
      shift_addr = rel[0];
    end else if (step < L_DAT) begin
      pins.cs = 1'b1;
    end else if (step < L_TAIL) begin
      rel        = step - L_DAT;
      pins.cs    = 1'b1;
      pins.sck   = ~rel[0];
      sample_bit = rel[0];
    end else begin
      rel = step - L_TAIL;
      case (rel[1:0])
        2'd1:    pins.cs  = 1'b1;
        2'd3:    pins.sck = 1'b1;
        default: pins = '0;
      endcase
    end
  end
endmodule

// File: rtl/eerd_word_shift.sv
module eerd_word_shift #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [DATA_W-1:0] swapped
);
  localparam int NBYTES = DATA_W / 8;

  logic [DATA_W-1:0] sr_q, sr_n;

  always_comb begin
    if (clear)         sr_n = '0;
    else if (shift_en) sr_n = {sr_q[DATA_W-2:0], bit_in};
    else               sr_n = sr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_n;
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign swapped[8*b +: 8] = sr_q[DATA_W-8-8*b +: 8];
  end
endmodule

// File: rtl/eeprom_word_reader.sv
module eeprom_word_reader
  import eerd_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int STEP_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              mem_cs,
  output logic              mem_sck,
  output logic              mem_mosi,
  input  logic              mem_miso
);
  localparam int NUM_STEPS = total_steps(ADDR_W, DATA_W);
  localparam int STEP_W    = $clog2(NUM_STEPS);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(NUM_STEPS - 1);

  logic              busy_q, busy_n;
  logic [STEP_W-1:0] step_q, step_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  ee_pins_t          pins_q, dec_pins;
  logic              shift_q, sample_q, dec_shift, dec_sample;
  logic [DATA_W-1:0] result_q, result_n, swapped;
  logic              done_q;
  logic              launch, step_end, last_step, advance, finish, pins_en;

  assign launch    = start && !busy_q;
  assign last_step = (step_q == STEP_LAST);
  assign advance   = step_end && !last_step;
  assign finish    = step_end && last_step;
  assign pins_en   = launch || advance;

  eerd_step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy_q),
    .clear    (launch),
    .step_end (step_end)
  );

  eerd_step_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STEP_W(STEP_W)) u_decode (
    .step       (step_n),
    .addr_msb   (addr_n[ADDR_W-1]),
    .pins       (dec_pins),
    .shift_addr (dec_shift),
    .sample_bit (dec_sample)
  );

  eerd_word_shift #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (launch),
    .shift_en (step_end && sample_q),
    .bit_in   (mem_miso),
    .swapped  (swapped)
  );

  always_comb begin
    busy_n   = busy_q;
    step_n   = step_q;
    addr_n   = addr_q;
    result_n = result_q;
    if (launch) begin
      busy_n = 1'b1;
      step_n = '0;
      addr_n = rd_addr;
    end else begin
      if (advance)             step_n = step_q + 1'b1;
      if (finish)              busy_n = 1'b0;
      if (step_end && shift_q) addr_n = {addr_q[ADDR_W-2:0], 1'b0};
      if (finish)              result_n = swapped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      step_q   <= '0;
      addr_q   <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      busy_q   <= busy_n;
      step_q   <= step_n;
      addr_q   <= addr_n;
      result_q <= result_n;
      done_q   <= finish;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q   <= '0;
      shift_q  <= 1'b0;
      sample_q <= 1'b0;
    end else if (pins_en) begin
      pins_q   <= dec_pins;
      shift_q  <= dec_shift;
      sample_q <= dec_sample;
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign rd_data  = result_q;
  assign mem_cs   = pins_q.cs;
  assign mem_sck  = pins_q.sck;
  assign mem_mosi = pins_q.mosi;
endmodule

// File: rtl/eerd_checker.sv
module eerd_checker
  import eerd_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int STEP_CYCLES = 4
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic mem_cs,
  input logic mem_sck,
  input logic mem_mosi
);
  localparam int RUN_CYCLES = total_steps(ADDR_W, DATA_W) * STEP_CYCLES;

  logic [2:0] pins, pins_prev;
  int         held;
  int         busy_cnt;

  assign pins = {mem_cs, mem_sck, mem_mosi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_prev <= '0;
      held      <= STEP_CYCLES;
      busy_cnt  <= 0;
    end else begin
      pins_prev <= pins;
      if (pins != pins_prev)     held <= 1;
      else if (held < STEP_CYCLES) held <= held + 1;
      busy_cnt <= busy ? busy_cnt + 1 : 0;
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (!busy && !done && !mem_cs && !mem_sck && !mem_mosi));

  a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  a_r3_step_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (pins != pins_prev) |-> (held >= STEP_CYCLES));

  a_r5_data_with_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_mosi != $past(mem_mosi)) |-> !mem_sck);

  a_r7_tail_state: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (mem_sck && !mem_cs && !mem_mosi));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r10_run_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == RUN_CYCLES));
endmodule

bind eeprom_word_reader eerd_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STEP_CYCLES(STEP_CYCLES)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .mem_cs   (mem_cs),
  .mem_sck  (mem_sck),
  .mem_mosi (mem_mosi)
);

// File: tb/tb_eeprom_word_reader.sv
module tb_eeprom_word_reader;
  localparam int CLK_PERIOD = 10;
  localparam int D          = 2;
  localparam int NSTEPS     = 63;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [7:0]  rd_addr;
  logic        busy, done;
  logic [15:0] rd_data;
  logic        mem_cs, mem_sck, mem_mosi, mem_miso;

  int n_checks = 0;
  int n_fail   = 0;

  eeprom_word_reader #(.ADDR_W(8), .DATA_W(16), .STEP_CYCLES(D)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_addr(rd_addr),
    .busy(busy), .done(done), .rd_data(rd_data),
    .mem_cs(mem_cs), .mem_sck(mem_sck), .mem_mosi(mem_mosi), .mem_miso(mem_miso)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [15:0] mem_word(input logic [7:0] a);
    logic [15:0] p;
    p = {8'h00, a} * 16'd40503;
    return p ^ 16'h5A3C;
  endfunction

  function automatic logic [15:0] swap16(input logic [15:0] w);
    return {w[7:0], w[15:8]};
  endfunction

  // expected {cs,sck,mosi} for step k of a read of address a
  function automatic logic [2:0] exp_pins(input int k, input logic [7:0] a);
    int j;
    if (k < 4) begin
      case (k)
        1:       return 3'b100;
        2:       return 3'b110;
        3:       return 3'b100;
        default: return 3'b000;
      endcase
    end else if (k < 10) begin
      j = k - 4;
      return {1'b1, (j % 2) == 1, j < 4};
    end else if (k < 26) begin
      j = k - 10;
      return {1'b1, (j % 2) == 1, a[7 - j / 2]};
    end else if (k == 26) begin
      return 3'b100;
    end else if (k < 59) begin
      j = k - 27;
      return {1'b1, (j % 2) == 0, 1'b0};
    end else begin
      j = k - 59;
      case (j)
        1:       return 3'b100;
        3:       return 3'b010;
        default: return 3'b000;
      endcase
    end
  endfunction

  function automatic string phase_tag(input int k);
    if (k < 4)       return "R4";
    else if (k < 27) return "R5";
    else if (k < 59) return "R6";
    else             return "R7";
  endfunction

  // EEPROM model: waits for a start bit, takes 2 command + 8 address bits, then shifts data out
  int          m_cnt;
  bit          m_started;
  logic [9:0]  m_hdr;
  logic [9:0]  cap_hdr;
  logic [15:0] m_word;

  always @(posedge mem_sck or negedge mem_cs or negedge rst_n) begin
    if (!rst_n || !mem_cs) begin
      m_started = 1'b0;
      m_cnt     = 0;
      m_hdr     = '0;
      mem_miso  = 1'b0;
      if (!rst_n) cap_hdr = '0;
    end else if (!m_started) begin
      if (mem_mosi) m_started = 1'b1;
    end else if (m_cnt < 10) begin
      m_hdr = {m_hdr[8:0], mem_mosi};
      m_cnt++;
      if (m_cnt == 10) cap_hdr = m_hdr;
    end else if (m_cnt < 26) begin
      m_word   = mem_word(m_hdr[7:0]);
      mem_miso = m_word[25 - m_cnt];
      m_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_read(input logic [7:0] a, input bit inject);
    logic [3:0]  got;
    logic [3:0]  want;
    logic [15:0] exp_data;
    exp_data = swap16(mem_word(a));
    @(negedge clk);
    rd_addr = a;
    start   = 1'b1;
    @(negedge clk);
    start   = 1'b0;
    rd_addr = ~a;  // R2: address must already be latched
    for (int k = 0; k < NSTEPS; k++) begin
      for (int j = 0; j < D; j++) begin
        if (k != 0 || j != 0) @(negedge clk);
        if (inject && k == 20 && j == 0) begin
          start   = 1'b1;  // R9: request during a busy read
          rd_addr = a ^ 8'h3C;
        end else begin
          start = 1'b0;
        end
        got  = {busy, mem_cs, mem_sck, mem_mosi};
        want = {1'b1, exp_pins(k, a)};
        // R3: each step's state holds for all D cycles
        check(got == want, phase_tag(k), 32'(got), 32'(want));
      end
    end
    @(negedge clk);
    check(done && !busy, "R10", {30'd0, done, busy}, 32'h2);
    check(rd_data == exp_data, "R8", 32'(rd_data), 32'(exp_data));
    check({mem_cs, mem_sck, mem_mosi} == 3'b010, "R7", 32'({mem_cs, mem_sck, mem_mosi}), 32'h2);
    check(cap_hdr == {2'b10, a}, "R5", 32'(cap_hdr), 32'({2'b10, a}));
    if (inject) check(rd_data == exp_data, "R9", 32'(rd_data), 32'(exp_data));
    @(negedge clk);
    check(!done && rd_data == exp_data, "R8", {15'd0, done, rd_data}, 32'(exp_data));
    check({mem_cs, mem_sck, mem_mosi} == 3'b010, "R7", 32'({mem_cs, mem_sck, mem_mosi}), 32'h2);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    rst_n   = 1'b0;
    start   = 1'b0;
    rd_addr = 8'h00;
    seed    = $urandom(32'd1234);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({busy, done, mem_cs, mem_sck, mem_mosi} == 5'b0, "R1",
          32'({busy, done, mem_cs, mem_sck, mem_mosi}), 32'h0);
    check(rd_data == 16'h0, "R1", 32'(rd_data), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, done, mem_cs, mem_sck, mem_mosi} == 5'b0, "R1",
          32'({busy, done, mem_cs, mem_sck, mem_mosi}), 32'h0);

    run_read(8'h00, 1'b0);
    run_read(8'hFF, 1'b0);
    run_read(8'h80, 1'b0);
    run_read(8'h5A, 1'b1);
    for (int i = 0; i < 20; i++) begin
      run_read(8'($urandom), (i % 5) == 0);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule